// File: doc/BRIEF.md
# Freeze Button Stack-Watch Controller

This block decides when a cartridge freezer takes over the machine. A press of the debounced freeze button counts only if the button was held for longer than a set time and then let go. The release arms the freezer and raises both the maskable and the non-maskable interrupt requests. The block does not change the memory map at that point. It watches the CPU bus until the CPU pushes three bytes in a row onto the stack page. That push is the return address and status the CPU saves just before it fetches an interrupt vector.

When the third push completes, the block raises a freeze-lock output. This output forces the cartridge into its ultimax map with bank 0 at the top of memory, so the cartridge's vectors take the place of the system ROM's vectors. The same event drops the interrupt requests and locks out the button. The freeze state lasts until the control register logic pulses a restore strobe. If the CPU never services an interrupt, the block waits for ever and leaves the map alone. There is no timeout.

The register decoding, the memory arrays and the CPU are outside this block. The bus is sampled in the system clock domain. A bus cycle ends on a falling edge of phi2.

Top module: `freeze_ctl`

## Requirements
- R1: After reset, irq_pull_o, nmi_pull_o and freeze_map_o are 0 and btn_en_o is 1.
- R2: The armed state is entered when btn_i (1 = pressed) falls after it was sampled high on more than HOLD_CYC consecutive clocks, where HOLD_CYC = CLK_MHZ*HOLD_US (250 by default). If it was high on exactly HOLD_CYC clocks, the release has no effect.
- R3: The block never enters the armed state while the button is still held. Only the clock that samples the release can arm it.
- R4: While armed, irq_pull_o and nmi_pull_o are both 1, meaning each interrupt line is pulled low. Both are 0 in every other state.
- R5: While armed, three consecutive bus cycles that are writes (bus_rw_i = 0) to an address whose upper byte is 8'h01 enter the freeze state on the clock that samples the third phi2 fall. That clock clears the armed state and the interrupt requests and sets freeze_map_o to 1.
- R6: Any bus cycle that is a read, or that is not in page 8'h01, restarts the run of consecutive stack writes. Such an interrupted run does not enter the freeze state.
- R7: There is no timeout. The armed state lasts for any number of clocks without stack writes, and freeze_map_o stays 0 for all of that time.
- R8: While frozen, btn_en_o is 0, and any hold and release of the button, however long, leaves the interrupt requests at 0.
- R9: A pulse on restore_i while frozen leaves the freeze state on the next clock, so freeze_map_o becomes 0 and btn_en_o becomes 1. A pulse in any other state has no effect.
- R10: Stack writes while the block is not armed have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_i | input | 1 | Debounced freeze button, 1 = pressed |
| bus_addr_i | input | 16 | CPU address bus |
| bus_rw_i | input | 1 | CPU read/write, 1 = read, 0 = write |
| bus_phi2_i | input | 1 | CPU phase-2 clock; a bus cycle ends when it falls |
| restore_i | input | 1 | One-clock strobe from the control register to leave the freeze state |
| irq_pull_o | output | 1 | 1 = pull the maskable interrupt line low |
| nmi_pull_o | output | 1 | 1 = pull the non-maskable interrupt line low |
| freeze_map_o | output | 1 | 1 = force the ultimax map with bank 0 on top |
| btn_en_o | output | 1 | 1 = the freeze button is accepted |

## Verification
The hold qualifier gets two holds, one of exactly the threshold and one a single clock longer. This separates a strict comparison from a non-strict one and shows that the block arms only on release. The stack watcher is tried with three clean pushes, with runs broken by a stack read and by a write outside page one, and with pushes while the block is idle. These patterns separate a true consecutive-run detector from a plain counter of stack writes. A long idle stretch while armed checks that there is no timeout. Button holds and restore pulses in the frozen and the idle states check the lockout and that a restore only acts when frozen.

// File: rtl/frz_pkg.sv
package frz_pkg;
    // Upper address byte of the CPU stack page
    localparam logic [7:0] STACK_PAGE = 8'h01;
    // Number of back-to-back stack pushes that precede a vector fetch
    localparam int unsigned STACK_RUN = 3;

    typedef enum logic [1:0] {
        FRZ_IDLE   = 2'd0,
        FRZ_ARMED  = 2'd1,
        FRZ_FROZEN = 2'd2
    } frz_state_e;
endpackage

// File: rtl/frz_btn_qual.sv
module frz_btn_qual #(
    parameter int unsigned CLK_MHZ = 125,
    parameter int unsigned HOLD_US = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic btn_i,
    output logic qual_o
);
    localparam int unsigned HOLD_CYC = CLK_MHZ * HOLD_US;
    localparam int unsigned CW       = $clog2(HOLD_CYC + 2);
    localparam logic [CW-1:0] LIMIT  = CW'(HOLD_CYC);
    localparam logic [CW-1:0] SAT    = CW'(HOLD_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } qual_st_t;

    qual_st_t st_d, st_q;
    logic     qual_c;

    always_comb begin
        st_d   = st_q;
        qual_c = 1'b0;
        if (!enable_i) begin
            st_d.cnt = '0;
        end else if (btn_i) begin
            if (st_q.cnt != SAT) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            qual_c   = (st_q.cnt > LIMIT);
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign qual_o = qual_c;

    // R3: a qualified press is only reported on a release
    p_qual_on_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        qual_o |-> !btn_i);
    // R2: a qualified press needs a hold count above the threshold
    p_qual_needs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        qual_o |-> (st_q.cnt == SAT));
endmodule

// File: rtl/frz_stack_mon.sv
module frz_stack_mon
    import frz_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rw_i,
    input  logic              phi2_i,
    output logic              push_done_o
);
    localparam int unsigned RW = $clog2(STACK_RUN);
    localparam logic [RW-1:0] LAST = RW'(STACK_RUN - 1);

    typedef struct packed {
        logic          phi2;
        logic [RW-1:0] run;
    } mon_st_t;

    mon_st_t st_d, st_q;
    logic    cyc_end_c;
    logic    stack_wr_c;
    logic    done_c;

    always_comb begin
        st_d       = st_q;
        st_d.phi2  = phi2_i;
        cyc_end_c  = st_q.phi2 && !phi2_i;
        stack_wr_c = !rw_i && (addr_i[ADDR_W-1:ADDR_W-8] == STACK_PAGE);
        done_c     = 1'b0;
        if (!arm_i) begin
            st_d.run = '0;
        end else if (cyc_end_c) begin
            if (stack_wr_c) begin
                if (st_q.run == LAST) begin
                    done_c   = 1'b1;
                    st_d.run = '0;
                end else begin
                    st_d.run = st_q.run + 1'b1;
                end
            end else begin
                st_d.run = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign push_done_o = done_c;

    // R6: the run counter never passes the final push index
    p_run_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run <= LAST);
    // R6: a cycle end that is not a stack write leaves an empty run
    p_run_breaks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && cyc_end_c && !stack_wr_c) |=> (st_q.run == '0));
    // R10: no completion while not armed
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |-> !push_done_o);
endmodule

// File: rtl/frz_flags.sv
module frz_flags
    import frz_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic qual_i,
    input  logic push_done_i,
    input  logic restore_i,
    output logic armed_o,
    output logic frozen_o
);
    typedef struct packed {
        frz_state_e state;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            FRZ_IDLE: begin
                if (qual_i) begin
                    st_d.state = FRZ_ARMED;
                end
            end
            FRZ_ARMED: begin
                if (push_done_i) begin
                    st_d.state = FRZ_FROZEN;
                end
            end
            FRZ_FROZEN: begin
                if (restore_i) begin
                    st_d.state = FRZ_IDLE;
                end
            end
            default: st_d.state = FRZ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= FRZ_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed_o  = (st_q.state == FRZ_ARMED);
    assign frozen_o = (st_q.state == FRZ_FROZEN);

    // R5: armed and frozen are never both set
    p_flags_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed_o && frozen_o));
    // R5: the freeze state is only reached from the armed state
    p_freeze_from_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frozen_o) |-> $past(armed_o));
    // R7: the armed state holds until the push run completes
    p_armed_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_o && !push_done_i) |=> armed_o);
    // R8: while frozen only a restore leaves, and nothing re-arms
    p_frozen_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_o && !restore_i) |=> (frozen_o && !armed_o));
    // R9: a restore while frozen returns to idle
    p_restore_exits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_o && restore_i) |=> (!frozen_o && !armed_o));
endmodule

// File: rtl/freeze_ctl.sv
module freeze_ctl #(
    parameter int unsigned CLK_MHZ = 125,
    parameter int unsigned HOLD_US = 2,
    parameter int unsigned ADDR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              btn_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_rw_i,
    input  logic              bus_phi2_i,
    input  logic              restore_i,
    output logic              irq_pull_o,
    output logic              nmi_pull_o,
    output logic              freeze_map_o,
    output logic              btn_en_o
);
    logic qual_w;
    logic push_done_w;
    logic armed_w;
    logic frozen_w;

    frz_btn_qual #(
        .CLK_MHZ (CLK_MHZ),
        .HOLD_US (HOLD_US)
    ) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (!frozen_w),
        .btn_i    (btn_i),
        .qual_o   (qual_w)
    );

    frz_stack_mon #(
        .ADDR_W (ADDR_W)
    ) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_i       (armed_w),
        .addr_i      (bus_addr_i),
        .rw_i        (bus_rw_i),
        .phi2_i      (bus_phi2_i),
        .push_done_o (push_done_w)
    );

    frz_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .qual_i      (qual_w),
        .push_done_i (push_done_w),
        .restore_i   (restore_i),
        .armed_o     (armed_w),
        .frozen_o    (frozen_w)
    );

    assign irq_pull_o   = armed_w;
    assign nmi_pull_o   = armed_w;
    assign freeze_map_o = frozen_w;
    assign btn_en_o     = !frozen_w;

    // R4: both interrupt requests move together
    p_irq_nmi_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pull_o == nmi_pull_o);
    // R8: the button is never enabled while the freeze map is forced
    p_lockout_r8: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_map_o |-> !btn_en_o);
    // R5: entering the freeze map drops the interrupt requests
    p_release_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(freeze_map_o) |-> !irq_pull_o);
endmodule

// File: tb/freeze_ctl_tb.sv
module freeze_ctl_tb_top;
    localparam int HOLD = 250;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        btn = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        rw = 1'b1;
    logic        phi2 = 1'b0;
    logic        restore = 1'b0;
    logic        irq_pull, nmi_pull, fmap, btn_en;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    freeze_ctl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .btn_i        (btn),
        .bus_addr_i   (addr),
        .bus_rw_i     (rw),
        .bus_phi2_i   (phi2),
        .restore_i    (restore),
        .irq_pull_o   (irq_pull),
        .nmi_pull_o   (nmi_pull),
        .freeze_map_o (fmap),
        .btn_en_o     (btn_en)
    );

    // Behavioural reference: mode 0 idle, 1 armed, 2 frozen
    int m_mode  = 0;
    int m_held  = 0;
    int m_pushes = 0;
    bit m_phi   = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_held = 0; m_pushes = 0; m_phi = 0;
        end else begin
            int nxt;
            nxt = m_mode;
            if (m_mode == 2) begin
                m_held = 0;
                if (restore) nxt = 0;
            end else if (btn) begin
                m_held++;
            end else begin
                if (m_mode == 0 && m_held > HOLD) nxt = 1;
                m_held = 0;
            end
            if (m_mode != 1) begin
                m_pushes = 0;
            end else if (m_phi && !phi2) begin
                if (!rw && addr[15:8] == 8'h01) begin
                    m_pushes++;
                    if (m_pushes == 3) begin
                        nxt = 2;
                        m_pushes = 0;
                    end
                end else begin
                    m_pushes = 0;
                end
            end
            m_phi  = phi2;
            m_mode = nxt;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Per-clock comparison against the reference
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check("R4", "irq_pull", int'(irq_pull), int'(m_mode == 1));
            check("R4", "nmi_pull", int'(nmi_pull), int'(m_mode == 1));
            check("R5", "freeze_map", int'(fmap), int'(m_mode == 2));
            check("R8", "btn_en", int'(btn_en), int'(m_mode != 2));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press(input int n);
        @(negedge clk);
        btn = 1'b1;
        idle(n);
        btn = 1'b0;
        idle(2);
    endtask

    task automatic bus_cyc(input logic [15:0] a, input logic wr);
        @(negedge clk);
        addr = a; rw = !wr; phi2 = 1'b1;
        idle(2);
        phi2 = 1'b0;
        idle(2);
        rw = 1'b1;
    endtask

    task automatic pulse_restore();
        @(negedge clk);
        restore = 1'b1;
        @(negedge clk);
        restore = 1'b0;
        idle(1);
    endtask

    initial begin
        idle(3);
        check("R1", "irq after reset", int'(irq_pull), 0);
        check("R1", "nmi after reset", int'(nmi_pull), 0);
        check("R1", "map after reset", int'(fmap), 0);
        check("R1", "btn_en after reset", int'(btn_en), 1);
        rst_n = 1'b1;
        idle(2);

        // R10: pushes while idle do nothing
        bus_cyc(16'h01FF, 1'b1); bus_cyc(16'h01FE, 1'b1); bus_cyc(16'h01FD, 1'b1);
        check("R10", "map after idle pushes", int'(fmap), 0);

        // R2: exactly the threshold does not arm
        press(HOLD);
        check("R2", "irq after threshold hold", int'(irq_pull), 0);

        // R3/R2: one clock longer arms, only after release
        @(negedge clk);
        btn = 1'b1;
        idle(HOLD + 1);
        check("R3", "irq while held", int'(irq_pull), 0);
        btn = 1'b0;
        idle(1);
        check("R2", "irq after long hold", int'(irq_pull), 1);
        check("R4", "nmi after long hold", int'(nmi_pull), 1);

        // R6: broken runs
        bus_cyc(16'h01F0, 1'b1); bus_cyc(16'h01EF, 1'b1); bus_cyc(16'h01EE, 1'b0);
        bus_cyc(16'h01ED, 1'b1); bus_cyc(16'h0200, 1'b1); bus_cyc(16'h01EC, 1'b1);
        bus_cyc(16'h01EB, 1'b1);
        check("R6", "map after broken runs", int'(fmap), 0);
        check("R6", "still armed", int'(irq_pull), 1);

        // R7: no timeout
        idle(1000);
        check("R7", "armed after long wait", int'(irq_pull), 1);
        check("R7", "map after long wait", int'(fmap), 0);

        // R5: three clean pushes
        bus_cyc(16'h01FF, 1'b1); bus_cyc(16'h01FE, 1'b1); bus_cyc(16'h01FD, 1'b1);
        check("R5", "map after pushes", int'(fmap), 1);
        check("R5", "irq released", int'(irq_pull), 0);
        check("R8", "btn_en while frozen", int'(btn_en), 0);

        // R8: button ignored while frozen
        press(HOLD + 50);
        check("R8", "irq after frozen press", int'(irq_pull), 0);
        check("R8", "map after frozen press", int'(fmap), 1);

        // R9: restore exits, second restore does nothing
        pulse_restore();
        check("R9", "map after restore", int'(fmap), 0);
        check("R9", "btn_en after restore", int'(btn_en), 1);
        pulse_restore();
        check("R9", "irq after idle restore", int'(irq_pull), 0);
        check("R9", "map after idle restore", int'(fmap), 0);

        // R9: restore while armed has no effect
        press(HOLD + 5);
        pulse_restore();
        check("R9", "armed after restore", int'(irq_pull), 1);

        // R1: reset while armed
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        check("R1", "irq after mid reset", int'(irq_pull), 0);
        check("R1", "btn_en after mid reset", int'(btn_en), 1);
        rst_n = 1'b1;
        idle(3);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule